// File: doc/BRIEF.md
# PWM emergency shutdown controller

This block sits between the PWM channel outputs and the pins. When shutdown is enabled, the pin of the highest channel becomes an input that can stop the PWM in an emergency. That pin's value passes through a two-flop synchronizer. When the synchronized value matches the programmed polarity, every enabled channel output is forced to a programmed idle level. Disabled channels keep passing their waveform unchanged. A sticky flag records each entry into shutdown.

To leave shutdown, the shutdown input must first go inactive, and then a restart strobe arms the release. Each channel then resumes its PWM waveform on the first counter-zero indication it receives. A concatenated pair waits until both of its 8-bit counters are zero at the same time, which is the zero of the 16-bit counter. While the low-power input is high, all counter-zero indications are ignored, so the outputs keep the idle level through that period.

Top module: `esd_ctrl`

## Requirements
- R1: After reset, no channel is in shutdown, sd_active_o and sd_flag_o are 0, and pwm_o equals pwm_i.
- R2: With sd_en_i=1 and ch_en_i[N_CH-1]=0, a synchronized sd_pin_i equal to sd_pol_i puts the block into shutdown by the third rising clock edge. From then on, each channel with ch_en_i set drives sd_lvl_i on pwm_o, and each channel with ch_en_i clear passes pwm_i.
- R3: The active level of sd_pin_i follows sd_pol_i. With sd_pol_i=0, a low pin triggers shutdown and a high pin does not.
- R4: A restart_i pulse is ignored while the synchronized shutdown input is still active. Once that input is inactive, a restart_i pulse arms the release. After that, each channel in a non-concatenated position returns to pwm_i at the clock edge after its own cnt_zero_i bit is seen high. Until then, the channel holds the idle level.
- R5: When concat_i[k]=1, channels 2k and 2k+1 are released only when cnt_zero_i[2k] and cnt_zero_i[2k+1] are both high in the same cycle. A zero on only one of the two leaves both channels at the idle level.
- R6: While lowpwr_i=1, counter-zero indications release no channel, even when the release is armed.
- R7: While ch_en_i[N_CH-1]=1, an active level on sd_pin_i does not trigger shutdown, and pwm_o keeps equal to pwm_i.
- R8: sd_flag_o is set on entry into shutdown and stays set through restart. A one on sd_clr_i clears it at the next edge. A new entry in the same cycle takes priority over the clear.
- R9: With sd_en_i=0, shutdown is cancelled at the next edge and pwm_o equals pwm_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sd_en_i | input | 1 | Emergency shutdown enable |
| sd_pol_i | input | 1 | Active level of the shutdown input |
| sd_lvl_i | input | 1 | Idle level driven during shutdown |
| sd_pin_i | input | 1 | Raw level of the highest channel's pin |
| restart_i | input | 1 | Restart strobe |
| sd_clr_i | input | 1 | Write-one clear of the sticky flag |
| lowpwr_i | input | 1 | Low-power mode active |
| ch_en_i | input | N_CH | Per-channel PWM enable |
| concat_i | input | N_CH/2 | Per-pair 16-bit concatenation |
| cnt_zero_i | input | N_CH | Per-channel counter-zero indication |
| pwm_i | input | N_CH | PWM waveforms from the channels |
| pwm_o | output | N_CH | Waveforms to the pins |
| sd_active_o | output | 1 | Some channel is held at the idle level |
| sd_flag_o | output | 1 | Sticky shutdown-entry flag |

## Verification
The assertions assume that sd_en_i, sd_pol_i, sd_lvl_i and ch_en_i change only at configuration points, away from transitions of shutdown. They also assume that the idle-level check on entry compares against a sd_lvl_i value that is stable in that cycle. The stimulus drives every input on the falling edge, and it changes configuration only when the block is idle or in a stable shutdown. Each restart and counter-zero pulse lasts one cycle, and each is issued only after the synchronizer has had time to settle.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} lvl_e;
endpackage

// File: rtl/esd_sync.sv
module esd_sync #(
  parameter int unsigned STAGES = esd_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic rst_val_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i ^ rst_val_i};
  end
  assign q_o = ff_q[STAGES-1] ^ rst_val_i;
endmodule

// File: rtl/esd_zero_map.sv
module esd_zero_map #(
  parameter int unsigned N_CH = 8,
  localparam int unsigned N_PAIR = N_CH / 2
) (
  input  logic [N_CH-1:0]   cnt_zero_i,
  input  logic [N_PAIR-1:0] concat_i,
  output logic [N_CH-1:0]   zero_o
);
  for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
    logic both;
    assign both = cnt_zero_i[2*k] & cnt_zero_i[2*k+1];
    assign zero_o[2*k]   = concat_i[k] ? both : cnt_zero_i[2*k];
    assign zero_o[2*k+1] = concat_i[k] ? both : cnt_zero_i[2*k+1];
  end
endmodule

// File: rtl/esd_hold.sv
module esd_hold #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            trig_i,
  input  logic            in_act_i,
  input  logic            restart_i,
  input  logic            lowpwr_i,
  input  logic            clr_i,
  input  logic [N_CH-1:0] zero_i,
  output logic [N_CH-1:0] hold_o,
  output logic            flag_o
);
  logic [N_CH-1:0] hold_q;
  logic            arm_q;
  logic            flag_q;
  logic [N_CH-1:0] rel;

  assign rel = {N_CH{arm_q & ~lowpwr_i}} & zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      arm_q  <= 1'b0;
    end else if (!en_i) begin
      hold_q <= '0;
      arm_q  <= 1'b0;
    end else if (trig_i) begin
      hold_q <= '1;
      arm_q  <= 1'b0;
    end else begin
      hold_q <= hold_q & ~rel;
      if (restart_i && !in_act_i && (hold_q != '0)) arm_q <= 1'b1;
      else if (hold_q == '0)                        arm_q <= 1'b0;
    end
  end

  // entry wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 flag_q <= 1'b0;
    else if (en_i && trig_i && hold_q == '0)     flag_q <= 1'b1;
    else if (clr_i)                              flag_q <= 1'b0;
  end

  assign hold_o = hold_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/esd_ctrl.sv
module esd_ctrl #(
  parameter int unsigned N_CH = 8,
  localparam int unsigned N_PAIR = N_CH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_en_i,
  input  logic              sd_pol_i,
  input  logic              sd_lvl_i,
  input  logic              sd_pin_i,
  input  logic              restart_i,
  input  logic              sd_clr_i,
  input  logic              lowpwr_i,
  input  logic [N_CH-1:0]   ch_en_i,
  input  logic [N_PAIR-1:0] concat_i,
  input  logic [N_CH-1:0]   cnt_zero_i,
  input  logic [N_CH-1:0]   pwm_i,
  output logic [N_CH-1:0]   pwm_o,
  output logic              sd_active_o,
  output logic              sd_flag_o
);
  logic            pin_s;
  logic            in_act;
  logic            trig;
  logic [N_CH-1:0] zero_grp;
  logic [N_CH-1:0] hold;
  logic [N_CH-1:0] force_m;

  esd_sync #(.STAGES(esd_pkg::SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sd_pin_i),
    .rst_val_i(~sd_pol_i), .q_o(pin_s)
  );

  assign in_act = (pin_s == sd_pol_i);
  // pin is a shutdown input only while the top channel is not a PWM output
  assign trig   = sd_en_i & ~ch_en_i[N_CH-1] & in_act;

  esd_zero_map #(.N_CH(N_CH)) u_zero (
    .cnt_zero_i(cnt_zero_i), .concat_i(concat_i), .zero_o(zero_grp)
  );

  esd_hold #(.N_CH(N_CH)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sd_en_i), .trig_i(trig),
    .in_act_i(in_act), .restart_i(restart_i), .lowpwr_i(lowpwr_i),
    .clr_i(sd_clr_i), .zero_i(zero_grp), .hold_o(hold), .flag_o(sd_flag_o)
  );

  assign force_m     = hold & ch_en_i;
  assign pwm_o       = (pwm_i & ~force_m) | ({N_CH{sd_lvl_i}} & force_m);
  assign sd_active_o = |hold;
endmodule

// File: rtl/esd_ctrl_chk.sv
module esd_ctrl_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sd_en_i,
  input logic            sd_lvl_i,
  input logic            sd_clr_i,
  input logic            lowpwr_i,
  input logic [N_CH-1:0] ch_en_i,
  input logic [N_CH-1:0] pwm_i,
  input logic [N_CH-1:0] pwm_o,
  input logic            sd_active_o,
  input logic            sd_flag_o
);
  AST_ENTRY_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_active_o) |-> ((pwm_o & ch_en_i) == ({N_CH{sd_lvl_i}} & ch_en_i))); // R2
  AST_DISABLED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_o & ~ch_en_i) == (pwm_i & ~ch_en_i))); // R2
  AST_TOP_EN_NO_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_active_o && ch_en_i[N_CH-1]) |=> !sd_active_o); // R7
  AST_LOWPWR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_active_o && lowpwr_i && sd_en_i) |=> sd_active_o); // R6
  AST_FLAG_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_active_o) |-> sd_flag_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_flag_o && !sd_clr_i) |=> sd_flag_o); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_en_i |=> !sd_active_o); // R9
endmodule

bind esd_ctrl esd_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sd_en_i(sd_en_i), .sd_lvl_i(sd_lvl_i),
  .sd_clr_i(sd_clr_i), .lowpwr_i(lowpwr_i), .ch_en_i(ch_en_i), .pwm_i(pwm_i),
  .pwm_o(pwm_o), .sd_active_o(sd_active_o), .sd_flag_o(sd_flag_o)
);

// File: tb/sim_esd_ctrl.sv
`timescale 1ns/1ps
module sim_esd_ctrl;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sd_en = 0, sd_pol = 1, sd_lvl = 1, sd_pin = 0, restart = 0, sd_clr = 0, lowpwr = 0;
  logic [N-1:0] ch_en = '0, zero = '0, pwm = 8'hA5;
  logic [N/2-1:0] concat = '0;
  logic [N-1:0] pwm_o;
  logic active, flag;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  esd_ctrl #(.N_CH(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sd_en_i(sd_en), .sd_pol_i(sd_pol), .sd_lvl_i(sd_lvl),
    .sd_pin_i(sd_pin), .restart_i(restart), .sd_clr_i(sd_clr), .lowpwr_i(lowpwr),
    .ch_en_i(ch_en), .concat_i(concat), .cnt_zero_i(zero), .pwm_i(pwm),
    .pwm_o(pwm_o), .sd_active_o(active), .sd_flag_o(flag)
  );

  function automatic logic [N-1:0] exp_out(logic [N-1:0] held);
    logic [N-1:0] f = held & ch_en;
    return (pwm & ~f) | ({N{sd_lvl}} & f);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic pulse_zero(logic [N-1:0] m);
    zero = m; cyc(1); zero = '0;
  endtask

  task automatic do_restart;
    restart = 1; cyc(1); restart = 0;
  endtask

  task automatic enter_sd;
    sd_pin = sd_pol; cyc(4);
  endtask

  task automatic leave_pin;
    sd_pin = ~sd_pol; cyc(4);
  endtask

  task automatic t_reset;
    chk("R1 active", active, 0);
    chk("R1 flag", flag, 0);
    chk("R1 pass", pwm_o, pwm);
  endtask

  task automatic t_trigger;
    sd_en = 1; ch_en = 8'h7F; sd_lvl = 1; pwm = 8'hA5; concat = '0;
    enter_sd();
    chk("R2 active", active, 1);
    chk("R2 forced", pwm_o, exp_out('1));
    chk("R8 flag set", flag, 1);
    do_restart(); pulse_zero('1);
    chk("R4 restart ignored while asserted", pwm_o, exp_out('1));
  endtask

  task automatic t_restart;
    leave_pin();
    do_restart();
    chk("R4 held before zero", pwm_o, exp_out('1));
    pulse_zero(8'h0F);
    chk("R4 low half released", pwm_o, exp_out(8'hF0));
    pulse_zero(8'hF0);
    chk("R4 all released", pwm_o, pwm);
    chk("R4 inactive", active, 0);
    chk("R8 flag sticky", flag, 1);
    sd_clr = 1; cyc(1); sd_clr = 0;
    chk("R8 flag cleared", flag, 0);
  endtask

  task automatic t_concat;
    concat = 4'b0001; sd_lvl = 0; pwm = 8'h5A;
    enter_sd(); leave_pin(); do_restart();
    pulse_zero(8'hFD);
    chk("R5 pair held on half zero", pwm_o, exp_out(8'h03));
    pulse_zero(8'h03);
    chk("R5 pair released", pwm_o, pwm);
    concat = '0;
  endtask

  task automatic t_lowpwr;
    sd_lvl = 1; enter_sd(); leave_pin();
    lowpwr = 1; do_restart(); pulse_zero('1); pulse_zero('1);
    chk("R6 held in low power", pwm_o, exp_out('1));
    lowpwr = 0; pulse_zero('1);
    chk("R6 released after low power", pwm_o, pwm);
  endtask

  task automatic t_polarity;
    sd_pol = 0; sd_pin = 1; cyc(4);
    chk("R3 high pin no trigger", active, 0);
    sd_pin = 0; cyc(4);
    chk("R3 low pin triggers", active, 1);
    leave_pin(); do_restart(); pulse_zero('1);
    chk("R3 released", active, 0);
    sd_pol = 1; sd_pin = 0; cyc(4);
  endtask

  task automatic t_top_enabled;
    ch_en = 8'hFF; sd_pin = 1; cyc(6);
    chk("R7 no trigger", active, 0);
    chk("R7 pass", pwm_o, pwm);
    sd_pin = 0; cyc(4); ch_en = 8'h7F;
  endtask

  task automatic t_disable;
    enter_sd();
    chk("R9 pre", active, 1);
    sd_en = 0; cyc(1);
    chk("R9 cleared", active, 0);
    chk("R9 pass", pwm_o, pwm);
    sd_pin = 0; cyc(4);
  endtask

  task automatic t_flag_prio;
    sd_en = 1; sd_clr = 0;
    sd_pin = 1; cyc(2); sd_clr = 1; cyc(1); sd_clr = 0;
    chk("R8 entry beats clear", flag, 1);
    sd_en = 0; cyc(1); sd_pin = 0; cyc(4);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset(); t_trigger(); t_restart(); t_concat(); t_lowpwr();
    t_polarity(); t_top_enabled(); t_disable(); t_flag_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule